// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a byte-wide nonvolatile memory of 1K or 2K bytes. It watches the two-wire clock and data lines through synchronizers running on the system clock. It finds start, repeated start and stop conditions, and it checks the header byte that opens each transfer. It acknowledges the bytes it accepts and shifts read data back out. It pulls the data line low only through an open-drain enable.

The storage itself and its timed programming cycle sit in a separate write and address engine. The front end owns the address counter and presents it on `mem_addr`. The engine returns the addressed byte on `rd_data` in the same cycle. Each accepted write byte is handed over with a one-cycle `wr_stb`. A `wr_commit` pulse on stop tells the engine to program the staged bytes. While that cycle runs, the engine holds `busy` high. The front end then refuses every header, so a master can poll for completion.

In the 1K-byte build, one header select bit is compared with a strap input and the other two select bits supply the upper address bits. In the 2K-byte build, all three select bits are address bits.

Top module: `tws_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` is low and neither `wr_stb` nor `wr_commit` is asserted.
- R2: The header byte is sent MSB first, and its upper nibble must be 4'b1010. With any other nibble, the block leaves the ninth bit unacknowledged and ignores the bus until the next start.
- R3: With ADDR_W = 10, header bit 3 must equal `dev_sel` for the header to be acknowledged, and header bits [2:1] of a write header become address bits [9:8]. With ADDR_W = 11, header bits [3:1] become address bits [10:8] and no strap is compared. Header bit 0 set to 1 selects a read.
- R4: In a write transfer, the block drives a zero acknowledge after the header, after the 8-bit low address and after every data byte. Each data byte produces one `wr_stb` with the target address on `mem_addr` and the byte on `wr_data`. A stop that follows at least one complete data byte produces exactly one `wr_commit`. A stop that follows no data byte produces none.
- R5: After each data byte, only the low 5 address bits advance, and they wrap from 31 to 0 inside the same 32-byte page.
- R6: While `busy` is high, no header byte is acknowledged. Once `busy` is low, a valid header is acknowledged again.
- R7: A write header and low address byte, followed by a repeated start and a read header, return the byte stored at the address just set.
- R8: When the master acknowledges a read byte with a zero, the next byte comes from the next linear address. The address wraps from the last location to 0.
- R9: A read header with no preceding address phase returns the byte at the current address. After a read, the current address is the last address read plus one (linear). After a write, it is the last address written plus one within its page. The block changes SDA only while the synchronized SCL is low.
- R10: When the master answers a read byte with a one, the block releases SDA and sends no further data until the next start or stop.
- R11: A start inside a byte restarts header reception. A stop inside a byte returns the block to idle without a strobe for the partial byte and without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Resolved bus data line as seen at the pad |
| dev_sel | input | 1 | Strap compared with header bit 3 when ADDR_W = 10 |
| sda_oe | output | 1 | High pulls the data line low |
| mem_addr | output | ADDR_W | Current memory address for the engine |
| rd_data | input | 8 | Byte stored at `mem_addr`, from the engine |
| wr_stb | output | 1 | One-cycle strobe for an accepted write byte |
| wr_data | output | 8 | Write byte, valid with `wr_stb` |
| wr_commit | output | 1 | One-cycle request to program the staged bytes |
| busy | input | 1 | Engine programming cycle in progress |

## Verification
The bench builds the block with ADDR_W = 10 and PAGE_W = 5, with the strap tied high. This configuration brings the strap comparison and the two upper address bits taken from the header into reach. The bench sweeps all sixteen header nibbles and all eight select-field values, predicting each acknowledge arithmetically. It then exercises page wrap at a page boundary, a sequential read across the top of the 1K address space, and random reads spread over all four upper-address values. The current address that each transfer should leave behind is recomputed in the bench and compared on every current-address read.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_MADR, S_MADR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK, S_RWAIT
  } tws_state_e;

  typedef enum logic [2:0] {
    AOP_NONE, AOP_HI, AOP_LO, AOP_PAGE, AOP_LIN
  } addr_op_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // R2: the family nibble of a header word
  function automatic logic code_ok(input logic [7:0] w);
    return w[7:4] == DEV_CODE;
  endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_ff[SYNC_STAGES-1];
      sda_p  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges while the clock stays high
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tws_addr.sv
module tws_addr
  import tws_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  addr_op_e            op,
  input  logic [7:0]          lo_byte,
  input  logic [ADDR_W-9:0]   hi_bits,
  output logic [ADDR_W-1:0]   addr
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;

  // R5: advance inside the page only
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] off;
    off = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], off};
  endfunction

  // R8: linear advance, wraps at the top
  function automatic logic [ADDR_W-1:0] lin_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      unique case (op)
        AOP_HI:   hi_q   <= hi_bits;
        AOP_LO:   addr_q <= {hi_q, lo_byte};
        AOP_PAGE: addr_q <= page_next(addr_q);
        AOP_LIN:  addr_q <= lin_next(addr_q);
        default:  ;
      endcase
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              dev_sel,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output addr_op_e          aop,
  output logic [7:0]        lo_byte,
  output logic [ADDR_W-9:0] hi_bits,
  output logic              wr_stb,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              hdr_done
);
  localparam int HI_W = ADDR_W - 8;

  tws_state_e state;
  logic [3:0] cnt;
  logic [7:0] sr, tx;
  logic       rd_mode, mack, pend;
  logic       sel_ok, hdr_ok;

  // R3: strap comparison exists only in the 1K build
  generate
    if (ADDR_W >= 11) begin : g_nopin
      assign sel_ok = 1'b1;
    end else begin : g_pin
      assign sel_ok = (sr[3] == dev_sel);
    end
  endgenerate

  assign hdr_ok   = code_ok(sr) && sel_ok && !busy;  // R2 R3 R6
  assign hdr_done = (state == S_DEV) && scl_fall && (cnt == 4'd8)
                    && !start_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '0;
      sda_oe    <= 1'b0;
      rd_mode   <= 1'b0;
      mack      <= 1'b1;
      pend      <= 1'b0;
      aop       <= AOP_NONE;
      lo_byte   <= '0;
      hi_bits   <= '0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      wr_commit <= 1'b0;
      aop       <= AOP_NONE;
      if (start_evt) begin           // R11 restart header reception
        state  <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        pend   <= 1'b0;
      end else if (stop_evt) begin   // R4 commit, R11 abort
        state     <= S_IDLE;
        sda_oe    <= 1'b0;
        wr_commit <= pend;
        pend      <= 1'b0;
      end else begin
        unique case (state)
          S_DEV, S_MADR, S_WDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_DEV) begin
                if (hdr_ok) begin
                  sda_oe  <= 1'b1;
                  state   <= S_DEV_ACK;
                  rd_mode <= sr[0];
                  if (!sr[0]) begin
                    aop     <= AOP_HI;
                    hi_bits <= sr[HI_W:1];
                  end
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_MADR) begin
                sda_oe  <= 1'b1;
                state   <= S_MADR_ACK;
                aop     <= AOP_LO;
                lo_byte <= sr;
              end else begin
                sda_oe  <= 1'b1;
                state   <= S_WDAT_ACK;
                wr_stb  <= 1'b1;
                wr_data <= sr;
                pend    <= 1'b1;
                aop     <= AOP_PAGE;
              end
            end
          end
          S_DEV_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                aop    <= AOP_LIN;
                cnt    <= '0;
                state  <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_MADR;
              end
            end
          end
          S_MADR_ACK, S_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                mack   <= 1'b1;
                state  <= S_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= sda_s;
            end else if (scl_fall) begin
              if (!mack) begin           // R8 continue
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                aop    <= AOP_LIN;
                cnt    <= '0;
                state  <= S_RDAT;
              end else begin             // R10 hold released
                state <= S_RWAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              dev_sel,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_stb,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  input  logic              busy
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt, hdr_done;
  addr_op_e          aop;
  logic [7:0]        lo_byte;
  logic [ADDR_W-9:0] hi_bits;

  tws_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tws_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_sel(dev_sel), .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe),
    .aop(aop), .lo_byte(lo_byte), .hi_bits(hi_bits), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_commit(wr_commit), .hdr_done(hdr_done)
  );

  tws_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .op(aop), .lo_byte(lo_byte),
    .hi_bits(hi_bits), .addr(mem_addr)
  );
endmodule

// File: rtl/tws_eeprom_slave_chk.sv
module tws_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic hdr_done,
  input logic stop_evt,
  input logic wr_stb,
  input logic wr_commit
);
  // R9: the data line moves only during clock low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R6: header finished during a programming cycle is not acknowledged
  p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && busy) |=> !sda_oe);

  // R4: a commit follows a stop directly
  p_commit_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  // R4: every accepted byte is acknowledged
  p_stb_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_oe);

  // R11: a stop releases the line and strobes nothing
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && !wr_stb));

  // R4: strobe and commit never coincide
  p_stb_commit_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, wr_commit}));
endmodule

bind tws_eeprom_slave tws_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .busy(busy),
  .hdr_done(hdr_done), .stop_evt(stop_evt), .wr_stb(wr_stb),
  .wr_commit(wr_commit)
);

// File: tb/tb_tws_eeprom_slave.sv
module tb_tws_eeprom_slave;
  localparam int AW = 10;
  localparam int NMEM = 1 << AW;
  localparam int Q = 6;
  localparam int BUSY_CYC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic dev_sel = 1'b1;
  wire  sda_oe, wr_stb, wr_commit;
  wire  [AW-1:0] mem_addr;
  wire  [7:0] wr_data;
  logic [7:0] rd_data;
  logic busy;
  wire  sda_line = m_sda & ~sda_oe;

  tws_eeprom_slave #(.ADDR_W(AW), .PAGE_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .dev_sel(dev_sel), .sda_oe(sda_oe), .mem_addr(mem_addr),
    .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_commit(wr_commit), .busy(busy)
  );

  logic [7:0] mem [0:NMEM-1];
  logic [7:0] exp_mem [0:NMEM-1];
  int stg_a [0:63];
  logic [7:0] stg_d [0:63];
  int stg_n = 0, n_stb = 0, n_commit = 0, busy_cnt = 0;
  int checks = 0, fails = 0, cur_exp = 0;
  bit done = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic int pg_next(int a);
    return (a & ~31) | ((a + 1) & 31);
  endfunction

  function automatic logic [7:0] hdr(int a, logic rw);
    return {4'b1010, dev_sel, 2'((a >> 8) & 3), rw};
  endfunction

  // engine model: staging, commit, timed busy
  assign rd_data = mem[mem_addr];
  assign busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NMEM; i++) mem[i] <= pat(i);
    end else begin
      if (wr_stb && stg_n < 64) begin
        stg_a[stg_n] <= int'(mem_addr);
        stg_d[stg_n] <= wr_data;
        stg_n <= stg_n + 1;
        n_stb <= n_stb + 1;
      end
      if (wr_commit) begin
        for (int i = 0; i < stg_n; i++) mem[stg_a[i]] <= stg_d[i];
        stg_n <= 0;
        n_commit <= n_commit + 1;
        busy_cnt <= BUSY_CYC;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(output logic [7:0] b, input logic nack);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line}; tick(Q);
      m_scl = 1'b0;
    end
    tick(Q);
    m_sda = nack; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic wait_ready();
    while (busy) tick(1);
    tick(4);
  endtask

  task automatic set_addr(input int a, input string req);
    logic ack;
    bus_start();
    send_byte(hdr(a, 1'b0), ack);
    chk(ack, req, int'(ack), 1);
    send_byte(8'(a), ack);
    chk(ack, req, int'(ack), 1);
    cur_exp = a;
  endtask

  // R4 R5: page write with bench-side address arithmetic
  task automatic write_bytes(input int a, input int n, input int seed);
    logic ack;
    logic [7:0] d;
    int ea, c0;
    set_addr(a, "R4");
    ea = a;
    for (int k = 0; k < n; k++) begin
      d = 8'(seed + k * 13);
      ea = (a & ~31) | ((a + k) & 31);
      send_byte(d, ack);
      chk(ack, "R4 data ack", int'(ack), 1);
      chk(stg_a[k] == ea, "R5 strobe address", stg_a[k], ea);
      chk(stg_d[k] == d, "R4 strobe data", int'(stg_d[k]), int'(d));
      exp_mem[ea] = d;
    end
    cur_exp = pg_next(ea);
    c0 = n_commit;
    bus_stop();
    chk(n_commit == c0 + 1, "R4 commit", n_commit, c0 + 1);
    wait_ready();
  endtask

  task automatic read_run(input int a, input int n, input logic use_cur, input string req);
    logic ack;
    logic [7:0] b;
    int ad;
    if (use_cur) ad = cur_exp;
    else begin
      set_addr(a, req);
      ad = a;
    end
    bus_start();
    send_byte(hdr(0, 1'b1), ack);
    chk(ack, req, int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      get_byte(b, k == n - 1);
      chk(b == exp_mem[(ad + k) % NMEM], req, int'(b), int'(exp_mem[(ad + k) % NMEM]));
    end
    cur_exp = (ad + n) % NMEM;
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int s0, c0;
    for (int i = 0; i < NMEM; i++) exp_mem[i] = pat(i);
    tick(10);
    chk(!sda_oe && !wr_stb && !wr_commit, "R1", int'({sda_oe, wr_stb, wr_commit}), 0);
    rst_n = 1'b1;
    tick(10);
    chk(sda_line == 1'b1 && !sda_oe, "R1", int'(sda_oe), 0);

    // R2: sweep every family nibble
    for (int c = 0; c < 16; c++) begin
      bus_start();
      send_byte({4'(c), dev_sel, 2'b00, 1'b0}, ack);
      chk(ack == (c == 10), "R2", int'(ack), int'(c == 10));
      bus_stop();
    end

    // R3: sweep the select field; R4: header-only write commits nothing
    c0 = n_commit;
    for (int s = 0; s < 8; s++) begin
      bus_start();
      send_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk(ack == (((s >> 2) & 1) == int'(dev_sel)), "R3", int'(ack), int'(((s >> 2) & 1) == int'(dev_sel)));
      bus_stop();
    end
    chk(n_commit == c0, "R4 no data no commit", n_commit, c0);

    // R5: three bytes across the page end
    write_bytes(12'h21E, 3, 8'h40);
    // R6: header during busy gets no ack, then ack after
    s0 = 0;
    write_bytes(12'h0A3, 1, 8'h91);
    cur_exp = 12'h0A4;
    bus_start();
    send_byte(hdr(0, 1'b1), ack);
    bus_stop();
    wait_ready();
    c0 = n_commit;
    set_addr(12'h0C0, "R4");
    send_byte(8'h5A, ack);
    exp_mem[12'h0C0] = 8'h5A;
    cur_exp = 12'h0C1;
    bus_stop();
    bus_start();
    send_byte(hdr(0, 1'b0), ack);
    chk(!ack, "R6 busy write header", int'(ack), 0);
    bus_stop();
    chk(busy == 1'b1, "R6 busy window", int'(busy), 1);
    wait_ready();
    bus_start();
    send_byte(hdr(0, 1'b0), ack);
    chk(ack, "R6 ack after busy", int'(ack), 1);
    bus_stop();

    // R7: random reads of written and untouched cells
    read_run(12'h21E, 1, 1'b0, "R7");
    read_run(12'h200, 1, 1'b0, "R7 page wrap");
    read_run(12'h201, 1, 1'b0, "R7");
    read_run(0, 1, 1'b1, "R9 after read");
    write_bytes(12'h13F, 1, 8'h77);
    read_run(0, 1, 1'b1, "R9 after write at page end");
    read_run(12'h0C0, 1, 1'b0, "R7");

    // R8: sequential across the top of memory
    read_run(12'h3FE, 4, 1'b0, "R8");
    read_run(0, 1, 1'b1, "R9");
    for (int k = 0; k < 12; k++) read_run((k * 83 + 5) % NMEM, 2, 1'b0, "R7 sweep");

    // R10: after a one, no more data even when clocked
    set_addr(12'h010, "R10");
    bus_start();
    send_byte(hdr(0, 1'b1), ack);
    chk(ack, "R10", int'(ack), 1);
    get_byte(b, 1'b1);
    chk(b == exp_mem[12'h010], "R10 first byte", int'(b), int'(exp_mem[12'h010]));
    get_byte(b, 1'b0);
    chk(b == 8'hFF, "R10 line released", int'(b), 8'hFF);
    bus_stop();
    cur_exp = 12'h011;
    read_run(0, 1, 1'b1, "R9 after nack");

    // R11: start inside a header byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_byte(hdr(0, 1'b1), ack);
    chk(ack, "R11 restart", int'(ack), 1);
    get_byte(b, 1'b1);
    chk(b == exp_mem[cur_exp], "R11 restart data", int'(b), int'(exp_mem[cur_exp]));
    cur_exp = (cur_exp + 1) % NMEM;
    bus_stop();

    // R11: stop inside a data byte
    s0 = n_stb;
    c0 = n_commit;
    set_addr(12'h055, "R11");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    tick(20);
    chk(n_stb == s0, "R11 no strobe", n_stb, s0);
    chk(n_commit == c0, "R11 no commit", n_commit, c0);
    chk(!busy, "R11 engine idle", int'(busy), 0);
    read_run(0, 1, 1'b1, "R11 cell intact");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule